// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the register front end of a display attribute stage. Software reaches every attribute register through one byte-wide write port. A hidden phase flip-flop decides what each write means. In the index phase the byte selects a register and carries the video-enable flag. In the data phase the byte is stored into the register that was selected, and the port goes back to the index phase. Software cannot see the flip-flop. It forces a known phase by reading the input status register, which is modelled here as a one-cycle strobe.

The block holds sixteen palette entries and five control registers: mode, border (overscan) colour, plane mask, pixel pan and colour page. It feeds the display pipeline in two ways. It presents the pan value. It also turns each incoming pixel code into a colour byte one clock later, through the palette or unchanged, depending on the mode. While video-enable is low, that colour byte is the border colour.

The phase state machine has two states. PH_INDEX is the reset state. PH_DATA is entered after an index write. There are three named transitions:
- IDX_WRITE goes from PH_INDEX to PH_DATA on a write.
- DATA_WRITE goes from PH_DATA to PH_INDEX on a write.
- STATUS_CLEAR forces PH_INDEX on a status read, whichever state the machine is in.

Top module: `attr_ctrl_port`

## Requirements
- R1: Reset sets the following values:
  - phase = index phase
  - palette entry n = n
  - mode = 0x00, border colour = 0x00, plane mask = 0xF, pan = 0, colour page = 0
  - selected index = 0, video-enable = 0
  - `color_out` = 0x00
- R2: A status strobe (`stat_rd`) with no write in the same cycle returns the port to the index phase. No register changes.
- R3: A write in the index phase does three things: bits 4:0 become the selected index, bit 5 becomes video-enable, and the port enters the data phase.
- R4: A write in the data phase stores the byte into the selected register and returns the port to the index phase. The selected index and video-enable stay unchanged.
- R5: When `stat_rd` and `wr_en` are high in the same cycle, the write is taken as an index write and the port ends in the data phase.
- R6: The register map is as follows. Each register keeps only its low bits, and readback zero-extends them.

  | Index | Register | Bits kept |
  |---|---|---|
  | 0x00–0x0F | palette entries | 6 |
  | 0x10 | mode | 8 |
  | 0x11 | border colour | 8 |
  | 0x12 | plane mask | 4 |
  | 0x13 | pan | 4 |
  | 0x14 | colour page | 2 |

- R7: For selected indices 0x15 to 0x1F, a data write changes no register, and `rd_data` reads 0x00.
- R8: `rd_data` shows the register at the selected index in the same cycle. It is combinational, with no read strobe.
- R9: `pan_out` always equals the pan register.
- R10: `color_out` is registered. It reflects `pix_in` and the register state from the previous cycle. When video-enable was 0 in that cycle, `color_out` is the border colour.
- R11: With mode bit 6 clear, the colour is built as {colour page[1:0], palette[`pix_in`[3:0] & plane mask]}.
- R12: With mode bit 6 set, `pix_in` passes to `color_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Byte written to the port |
| stat_rd | input | 1 | Status-read strobe; clears the phase flip-flop |
| rd_data | output | 8 | Register at the selected index |
| pix_in | input | 8 | Pixel code from the display pipeline |
| color_out | output | 8 | Colour byte, one clock after `pix_in` |
| pan_out | output | 4 | Horizontal pixel pan value |
| video_en | output | 1 | Video-enable flag from the last index write |

## Verification
Two port functions can land on the same clock edge: the status strobe that clears the flip-flop, and a write on the shared port. The bench provokes this in two ways. It places both strobes in one cycle while the port is in the data phase. It also mixes them at random over several hundred cycles.

The behavioural model treats the strobe as resolving first. The write then counts as an index write, so the selected index, video-enable and the following data write must all match the model. Any misordering shows up as a wrong register value on `rd_data` or a wrong colour one clock later.

// File: rtl/ac_pkg.sv
package ac_pkg;
    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } ac_phase_e;

    localparam int unsigned IX_W = 5;
    localparam logic [IX_W-1:0] IX_MODE  = 5'h10;
    localparam logic [IX_W-1:0] IX_BORDR = 5'h11;
    localparam logic [IX_W-1:0] IX_PMASK = 5'h12;
    localparam logic [IX_W-1:0] IX_PAN   = 5'h13;
    localparam logic [IX_W-1:0] IX_PAGE  = 5'h14;
    localparam int unsigned VEN_BIT   = 5;
    localparam int unsigned BYPASS_BIT = 6;
endpackage

// File: rtl/ac_phase_fsm.sv
module ac_phase_fsm
    import ac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      stat_rd,
    output ac_phase_e phase_q,
    output logic      idx_load,
    output logic      data_load
);
    ac_phase_e phase_d;
    ac_phase_e cur;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_INDEX;
        else        phase_q <= phase_d;
    end

    always_comb begin
        cur       = stat_rd ? PH_INDEX : phase_q;  // STATUS_CLEAR resolves first
        phase_d   = cur;
        idx_load  = 1'b0;
        data_load = 1'b0;
        unique case (cur)
            PH_INDEX: begin
                if (wr_en) begin           // IDX_WRITE
                    idx_load = 1'b1;
                    phase_d  = PH_DATA;
                end
            end
            PH_DATA: begin
                if (wr_en) begin           // DATA_WRITE
                    data_load = 1'b1;
                    phase_d   = PH_INDEX;
                end
            end
            default: phase_d = PH_INDEX;
        endcase
    end
endmodule

// File: rtl/ac_regfile.sv
module ac_regfile
    import ac_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned PAL_ENTRIES = 16,
    parameter int unsigned PAL_W       = 6,
    parameter int unsigned PAN_W       = 4,
    localparam int unsigned PIDX_W     = $clog2(PAL_ENTRIES),
    localparam int unsigned PG_W       = DW - PAL_W
)(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                idx_load,
    input  logic                                data_load,
    input  logic [DW-1:0]                       wr_data,
    output logic                                ven_q,
    output logic [DW-1:0]                       rd_data,
    output logic [PAL_ENTRIES-1:0][PAL_W-1:0]   pal_q,
    output logic [DW-1:0]                       mode_q,
    output logic [DW-1:0]                       bordr_q,
    output logic [PIDX_W-1:0]                   pmask_q,
    output logic [PAN_W-1:0]                    pan_q,
    output logic [PG_W-1:0]                     page_q
);
    logic [IX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ven_q <= 1'b0;
        end else if (idx_load) begin
            idx_q <= wr_data[IX_W-1:0];
            ven_q <= wr_data[VEN_BIT];
        end
    end

    for (genvar g = 0; g < PAL_ENTRIES; g++) begin : g_pal
        always_ff @(posedge clk) begin
            if (!rst_n)
                pal_q[g] <= PAL_W'(g);
            else if (data_load && idx_q == IX_W'(g))
                pal_q[g] <= wr_data[PAL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            bordr_q <= '0;
            pmask_q <= '1;
            pan_q   <= '0;
            page_q  <= '0;
        end else if (data_load) begin
            unique case (idx_q)
                IX_MODE:  mode_q  <= wr_data;
                IX_BORDR: bordr_q <= wr_data;
                IX_PMASK: pmask_q <= wr_data[PIDX_W-1:0];
                IX_PAN:   pan_q   <= wr_data[PAN_W-1:0];
                IX_PAGE:  page_q  <= wr_data[PG_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (idx_q < IX_W'(PAL_ENTRIES)) begin
            rd_data = DW'(pal_q[idx_q[PIDX_W-1:0]]);
        end else begin
            unique case (idx_q)
                IX_MODE:  rd_data = mode_q;
                IX_BORDR: rd_data = bordr_q;
                IX_PMASK: rd_data = DW'(pmask_q);
                IX_PAN:   rd_data = DW'(pan_q);
                IX_PAGE:  rd_data = DW'(page_q);
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ac_pixel_path.sv
module ac_pixel_path
    import ac_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned PAL_ENTRIES = 16,
    parameter int unsigned PAL_W       = 6,
    localparam int unsigned PIDX_W     = $clog2(PAL_ENTRIES),
    localparam int unsigned PG_W       = DW - PAL_W
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [DW-1:0]                     pix_in,
    input  logic                              ven,
    input  logic                              bypass,
    input  logic [DW-1:0]                     bordr,
    input  logic [PIDX_W-1:0]                 pmask,
    input  logic [PG_W-1:0]                   page,
    input  logic [PAL_ENTRIES-1:0][PAL_W-1:0] pal,
    output logic [DW-1:0]                     color_out
);
    logic [PIDX_W-1:0] look_idx;
    logic [DW-1:0]     color_d;

    always_comb begin
        look_idx = pix_in[PIDX_W-1:0] & pmask;
        if (!ven)        color_d = bordr;
        else if (bypass) color_d = pix_in;
        else             color_d = {page, pal[look_idx]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) color_out <= '0;
        else        color_out <= color_d;
    end
endmodule

// File: rtl/attr_ctrl_port.sv
module attr_ctrl_port
    import ac_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned PAL_ENTRIES = 16,
    parameter int unsigned PAL_W       = 6,
    parameter int unsigned PAN_W       = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             stat_rd,
    output logic [DW-1:0]    rd_data,
    input  logic [DW-1:0]    pix_in,
    output logic [DW-1:0]    color_out,
    output logic [PAN_W-1:0] pan_out,
    output logic             video_en
);
    localparam int unsigned PIDX_W = $clog2(PAL_ENTRIES);
    localparam int unsigned PG_W   = DW - PAL_W;

    ac_phase_e                   phase_q;
    logic                        idx_load, data_load;
    logic                        in_data_phase;
    logic [PAL_ENTRIES-1:0][PAL_W-1:0] pal_q;
    logic [DW-1:0]               mode_q, bordr_q;
    logic [PIDX_W-1:0]           pmask_q;
    logic [PG_W-1:0]             page_q;

    assign in_data_phase = (phase_q == PH_DATA);

    ac_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stat_rd(stat_rd),
        .phase_q(phase_q), .idx_load(idx_load), .data_load(data_load)
    );

    ac_regfile #(.DW(DW), .PAL_ENTRIES(PAL_ENTRIES), .PAL_W(PAL_W), .PAN_W(PAN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .data_load(data_load),
        .wr_data(wr_data), .ven_q(video_en), .rd_data(rd_data), .pal_q(pal_q),
        .mode_q(mode_q), .bordr_q(bordr_q), .pmask_q(pmask_q), .pan_q(pan_out),
        .page_q(page_q)
    );

    ac_pixel_path #(.DW(DW), .PAL_ENTRIES(PAL_ENTRIES), .PAL_W(PAL_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .ven(video_en),
        .bypass(mode_q[BYPASS_BIT]), .bordr(bordr_q), .pmask(pmask_q),
        .page(page_q), .pal(pal_q), .color_out(color_out)
    );
endmodule

// File: rtl/attr_ctrl_port_chk.sv
module attr_ctrl_port_chk #(
    parameter int unsigned DW = 8
)(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          stat_rd,
    input logic          in_data_phase,
    input logic          video_en,
    input logic [DW-1:0] color_out,
    input logic [DW-1:0] bordr_q
);
    assert_status_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !wr_en) |=> !in_data_phase);

    assert_index_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_rd && !in_data_phase) |=> (in_data_phase && video_en == $past(wr_data[5])));

    assert_data_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_rd && in_data_phase) |=> (!in_data_phase && $stable(video_en)));

    assert_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stat_rd) |=> in_data_phase);

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stat_rd) |=> $stable(in_data_phase));

    assert_blank_border_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> color_out == $past(bordr_q));
endmodule

bind attr_ctrl_port attr_ctrl_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
    .in_data_phase(in_data_phase), .video_en(video_en), .color_out(color_out),
    .bordr_q(bordr_q)
);

// File: tb/attr_ctrl_port_bench.sv
module attr_ctrl_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] pix_in = '0;
    logic [7:0] rd_data, color_out;
    logic [3:0] pan_out;
    logic       video_en;

    always #5 clk = ~clk;

    attr_ctrl_port u_attr_ctrl_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .rd_data(rd_data), .pix_in(pix_in),
        .color_out(color_out), .pan_out(pan_out), .video_en(video_en)
    );

    // behavioural reference state
    int m_pal[16];
    int m_mode, m_bordr, m_pmask, m_pan, m_page, m_idx, m_ven, m_ph, m_col;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int unsigned lfsr = 32'h1D2C3B4A;

    function automatic int m_read();
        if (m_idx < 16) return m_pal[m_idx];
        case (m_idx)
            16: return m_mode;
            17: return m_bordr;
            18: return m_pmask;
            19: return m_pan;
            20: return m_page;
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_pal[i] = i;
        m_mode = 0; m_bordr = 0; m_pmask = 15; m_pan = 0; m_page = 0;
        m_idx = 0; m_ven = 0; m_ph = 0; m_col = 0;
    endtask

    task automatic m_clock(input bit w, input int d, input bit s, input int p);
        int eff;
        // colour uses the state before the edge
        if (m_ven == 0)              m_col = m_bordr;
        else if (m_mode & 8'h40)     m_col = p;
        else                         m_col = ((m_page & 3) << 6) | m_pal[(p & m_pmask) & 15];
        eff = s ? 0 : m_ph;
        if (w) begin
            if (eff == 0) begin
                m_idx = d & 31; m_ven = (d >> 5) & 1; m_ph = 1;
            end else begin
                if (m_idx < 16) m_pal[m_idx] = d & 63;
                else case (m_idx)
                    16: m_mode  = d;
                    17: m_bordr = d;
                    18: m_pmask = d & 15;
                    19: m_pan   = d & 15;
                    20: m_page  = d & 3;
                    default: ;
                endcase
                m_ph = 0;
            end
        end else begin
            m_ph = eff;
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "color_out", int'(color_out), m_col);
        check(tag, "rd_data",   int'(rd_data),   m_read());
        check(tag, "pan_out",   int'(pan_out),   m_pan);
        check(tag, "video_en",  int'(video_en),  m_ven);
    endtask

    task automatic step(input bit w, input int d, input bit s, input int p, input string tag);
        @(negedge clk);
        wr_en = w; wr_data = 8'(d); stat_rd = s; pix_in = 8'(p);
        @(posedge clk);
        m_clock(w, d, s, p);
        #2;
        compare_all(tag);
    endtask

    task automatic idle(input int p, input string tag);
        step(0, 0, 0, p, tag);
    endtask

    task automatic put(input int ix, input int val, input string tag);
        step(1, ix, 0, 0, tag);
        step(1, val, 0, 0, tag);
    endtask

    function automatic int rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr & 32'hFF);
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values seen at the ports
        compare_all("R1");
        @(negedge clk); rst_n = 1'b1;
        // R1 R8: walk the palette reset values through readback
        for (int i = 0; i < 16; i++) begin
            step(1, i, 0, 0, "R1");
            step(0, 0, 1, 0, "R8");
        end
        step(1, 8'h12, 0, 0, "R1"); step(0, 0, 1, 0, "R1");
        // R3 R4 R6: program palette and control registers, video on
        for (int i = 0; i < 16; i++) put(8'h20 | i, 8'hC0 | (15 - i) * 4, "R6");
        put(8'h31, 8'hA5, "R6");
        put(8'h32, 8'hF6, "R6");
        put(8'h33, 8'hFB, "R9");
        put(8'h34, 8'hFE, "R6");
        // R11: lookups through palette with mask 0x6 and page 2
        for (int p = 0; p < 20; p++) idle(p * 13, "R11");
        put(8'h32, 8'h0F, "R11");
        for (int p = 0; p < 16; p++) idle(p, "R11");
        // R2: strobe mid-sequence discards pending data phase
        step(1, 8'h33, 0, 0, "R3");
        step(0, 0, 1, 0, "R2");
        step(1, 8'h24, 0, 0, "R2");   // index again, not data for pan
        step(1, 8'h3F, 0, 0, "R4");
        step(0, 0, 1, 0, "R2");
        step(0, 0, 1, 0, "R2");
        // R5: strobe and write together while in data phase
        step(1, 8'h30, 0, 0, "R5");
        step(1, 8'h33, 1, 0, "R5");
        step(1, 8'h07, 0, 0, "R5");
        idle(0, "R9");
        // R7: unused indices ignore data and read zero
        for (int k = 21; k < 32; k++) put(8'h20 | k, 8'hFF, "R7");
        step(1, 8'h31, 0, 0, "R7"); step(1, 8'h31, 0, 0, "R7");
        step(1, 8'h32, 0, 0, "R7"); step(1, 8'h32, 0, 0, "R7");
        // R12: bypass mode passes pixel code straight through
        put(8'h30, 8'h41, "R12");
        for (int p = 0; p < 12; p++) idle(p * 21 + 3, "R12");
        put(8'h30, 8'h81, "R11");
        idle(5, "R11");
        // R10: blank with index bit 5 clear, border colour shown
        step(1, 8'h11, 0, 0, "R10");
        for (int p = 0; p < 6; p++) idle(p * 40, "R10");
        step(1, 8'h2A, 0, 0, "R10");   // data write to border while blanked
        for (int p = 0; p < 4; p++) idle(p, "R10");
        step(1, 8'h20, 0, 0, "R10");   // restore display
        step(0, 0, 1, 0, "R10");
        for (int p = 0; p < 6; p++) idle(p * 7, "R10");
        // mixed traffic including same-cycle strobe and write
        for (int n = 0; n < 600; n++) begin
            int a, b, c;
            a = rnd(); b = rnd(); c = rnd();
            if ((a & 3) != 0 && (b & 7) == 0) step(1, c, 1, rnd(), "R5");
            else if ((a & 3) != 0)            step(1, c, 0, rnd(), "R4");
            else if ((b & 7) == 1)            step(0, 0, 1, rnd(), "R2");
            else                              step(0, 0, 0, rnd(), "R11");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule